// File: doc/BRIEF.md
# 66-bit Block Scrambler and Descrambler

This block is the coding path of a serial link that carries 66-bit blocks. The transmit half takes a 64-bit payload and a flag saying whether the block holds control content. It scrambles the payload with a self-synchronizing multiplicative scrambler built on x^58 + x^39 + 1, handling 64 bits each clock. It then places a 2-bit sync header in front of the scrambled payload. The receive half takes 66-bit blocks and decodes the header. It descrambles the payload and flags blocks whose header is neither legal value.

Both halves use valid/ready handshakes on their input and output sides. Each half has a single registered output stage, so a block appears one clock after it is accepted. The header never passes through the scrambler or the descrambler. A shared bypass input sends payloads through both halves unscrambled, which is used for test.

Top module: `sync66_coder`

## Requirements
- R1: Each transmit block places its sync header in tx_block[1:0] without scrambling. The header is 2'b01 when tx_ctrl is 0 (data block) and 2'b10 when tx_ctrl is 1 (control block).
- R2: The transmit payload sits in tx_block[65:2], with payload bit 0 in tx_block[2] and treated as the first bit sent. For payload bits i = 0..63 in order, scrambled bit = in[i] XOR s[38] XOR s[57]. The scrambled bit is then shifted into the 58-bit state s at s[0], and the older bits move up one place. The state is all zero after reset.
- R3: The receiver uses the same formula on the received scrambled bits. It shifts the received bits, not its own output, into its state. A stream from a transmitter whose state matches the receiver's is returned as the original payloads.
- R4: The receiver needs no seeding. If it starts from a state unrelated to the transmitter's, every block after the first is descrambled correctly.
- R5: Receive header 2'b01 gives rx_ctrl=0 and rx_hdr_err=0. Header 2'b10 gives rx_ctrl=1 and rx_hdr_err=0. Headers 2'b00 and 2'b11 give rx_hdr_err=1 and rx_ctrl=0. The payload of such a block is still descrambled and still advances the state.
- R6: A single flipped received payload bit at position k corrupts exactly the output bits k, k+39 and k+58 of the stream and no others.
- R7: While bypass is 1 at the cycle a block is accepted, that half outputs the payload unchanged, still with its header handling, and its scrambler state is left unchanged.
- R8: On each side, in_ready = !out_valid || out_ready. An accepted block appears at the output on the next cycle. An output that is held (valid and not ready) keeps valid high and its data stable.
- R9: During and right after reset, tx_blk_valid and rx_valid are 0, and tx_ready and rx_blk_ready are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | Pass payloads unscrambled in both halves |
| tx_valid | input | 1 | Transmit payload valid |
| tx_ready | output | 1 | Transmit payload accepted when high with tx_valid |
| tx_ctrl | input | 1 | 1 = control block, 0 = data block |
| tx_payload | input | 64 | Transmit payload, bit 0 first |
| tx_blk_valid | output | 1 | Transmit block valid |
| tx_blk_ready | input | 1 | Downstream accepts the transmit block |
| tx_block | output | 66 | Header in [1:0], scrambled payload in [65:2] |
| rx_blk_valid | input | 1 | Received block valid |
| rx_blk_ready | output | 1 | Received block accepted when high with rx_blk_valid |
| rx_block | input | 66 | Received block, header in [1:0] |
| rx_valid | output | 1 | Descrambled payload valid |
| rx_ready | input | 1 | Downstream accepts the payload |
| rx_payload | output | 64 | Descrambled payload |
| rx_ctrl | output | 1 | Block carried control header 2'b10 |
| rx_hdr_err | output | 1 | Block header was 2'b00 or 2'b11 |

## Verification
The transmit half is driven with all-zero, all-one, alternating and counting payloads, mixing both header kinds. Because the scrambler state starts at zero, a constant payload shows whether both taps and the feedback order are right. The alternating and counting payloads catch bit-order swaps. The receive half gets streams scrambled in step with its own state, so a wrong feedback source shows up as corrupted payloads. It also gets a stream that starts from an unrelated state, which tells the self-synchronizing property apart from one that depends on a seed. A single-bit flip tests whether exactly three bits spread. All four header codes and the bypass path are tried, while the output side randomly withholds ready so that any unstable held data is exposed.

// File: rtl/c66_pkg.sv
package c66_pkg;
  localparam int PLD_W   = 64;
  localparam int HDR_W   = 2;
  localparam int BLK_W   = PLD_W + HDR_W;
  localparam int LFSR_W  = 58;
  localparam int TAP_MID = 39;
  localparam int RUN_W   = LFSR_W + PLD_W;

  localparam logic [HDR_W-1:0] HDR_DATA = 2'b01;
  localparam logic [HDR_W-1:0] HDR_CTRL = 2'b10;

  // Runs PLD_W bit steps of the x^58 + x^39 + 1 recursion, bit 0 first.
  // feed_rx=1 shifts the input bits into the state (descrambler),
  // feed_rx=0 shifts the output bits (scrambler). Returns {state, bits}.
  function automatic logic [RUN_W-1:0] lfsr_run(
    input logic [LFSR_W-1:0] st_in,
    input logic [PLD_W-1:0]  din,
    input logic              feed_rx
  );
    logic [LFSR_W-1:0] st;
    logic [PLD_W-1:0]  dout;
    logic              fb;
    st = st_in;
    dout = '0;
    for (int i = 0; i < PLD_W; i++) begin
      dout[i] = din[i] ^ st[TAP_MID-1] ^ st[LFSR_W-1];
      fb = feed_rx ? din[i] : dout[i];
      st = {st[LFSR_W-2:0], fb};
    end
    return {st, dout};
  endfunction
endpackage

// File: rtl/c66_pipe_reg.sv
module c66_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data)); // R8
endmodule

// File: rtl/c66_tx_scr.sv
module c66_tx_scr
  import c66_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bypass,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_ctrl,
  input  logic [PLD_W-1:0] in_payload,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BLK_W-1:0] out_block
);
  logic [LFSR_W-1:0] st_q;
  logic [RUN_W-1:0]  run;
  logic [PLD_W-1:0]  pld_c;
  logic [HDR_W-1:0]  hdr_c;
  logic              fire;

  assign run   = lfsr_run(st_q, in_payload, 1'b0);
  assign pld_c = bypass ? in_payload : run[PLD_W-1:0];
  assign hdr_c = in_ctrl ? HDR_CTRL : HDR_DATA;
  assign fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else if (fire && !bypass) st_q <= run[RUN_W-1:PLD_W];
  end

  c66_pipe_reg #(.W(BLK_W)) u_out (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data({pld_c, hdr_c}),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_block)
  );

  AST_TX_HDR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_block[1:0] == HDR_DATA || out_block[1:0] == HDR_CTRL)); // R1
  AST_TX_BYPASS_FREEZE: assert property (@(posedge clk) disable iff (rst)
    fire && bypass |=> $stable(st_q)); // R7
  AST_TX_BYPASS_RAW: assert property (@(posedge clk) disable iff (rst)
    fire && bypass |=> out_block[BLK_W-1:HDR_W] == $past(in_payload)); // R7
  AST_TX_FEED_OUT: assert property (@(posedge clk) disable iff (rst)
    fire && !bypass |=> st_q[0] == out_block[BLK_W-1]); // R2
endmodule

// File: rtl/c66_rx_descr.sv
module c66_rx_descr
  import c66_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bypass,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BLK_W-1:0] in_block,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PLD_W-1:0] out_payload,
  output logic             out_ctrl,
  output logic             out_err
);
  localparam int OW = PLD_W + 2;

  logic [LFSR_W-1:0] st_q;
  logic [RUN_W-1:0]  run;
  logic [PLD_W-1:0]  wire_pld;
  logic [HDR_W-1:0]  hdr;
  logic [PLD_W-1:0]  pld_c;
  logic              bad_hdr, is_ctrl, fire;
  logic [OW-1:0]     q;

  assign hdr      = in_block[HDR_W-1:0];
  assign wire_pld = in_block[BLK_W-1:HDR_W];
  assign run      = lfsr_run(st_q, wire_pld, 1'b1);
  assign pld_c    = bypass ? wire_pld : run[PLD_W-1:0];
  assign bad_hdr  = (hdr != HDR_DATA) && (hdr != HDR_CTRL);
  assign is_ctrl  = (hdr == HDR_CTRL);
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else if (fire && !bypass) st_q <= run[RUN_W-1:PLD_W];
  end

  c66_pipe_reg #(.W(OW)) u_out (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data({bad_hdr, is_ctrl, pld_c}),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(q)
  );

  assign out_payload = q[PLD_W-1:0];
  assign out_ctrl    = q[PLD_W];
  assign out_err     = q[PLD_W+1];

  AST_RX_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_err == ($past(in_block[1:0]) inside {2'b00, 2'b11})); // R5
  AST_RX_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_err && out_ctrl)); // R5
  AST_RX_FEED_IN: assert property (@(posedge clk) disable iff (rst)
    fire && !bypass |=> st_q[0] == $past(in_block[BLK_W-1])); // R3
  AST_RX_BYPASS_FREEZE: assert property (@(posedge clk) disable iff (rst)
    fire && bypass |=> $stable(st_q)); // R7
endmodule

// File: rtl/sync66_coder.sv
module sync66_coder
  import c66_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bypass,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic             tx_ctrl,
  input  logic [PLD_W-1:0] tx_payload,
  output logic             tx_blk_valid,
  input  logic             tx_blk_ready,
  output logic [BLK_W-1:0] tx_block,
  input  logic             rx_blk_valid,
  output logic             rx_blk_ready,
  input  logic [BLK_W-1:0] rx_block,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [PLD_W-1:0] rx_payload,
  output logic             rx_ctrl,
  output logic             rx_hdr_err
);
  c66_tx_scr u_tx (
    .clk(clk), .rst(rst), .bypass(bypass),
    .in_valid(tx_valid), .in_ready(tx_ready),
    .in_ctrl(tx_ctrl), .in_payload(tx_payload),
    .out_valid(tx_blk_valid), .out_ready(tx_blk_ready), .out_block(tx_block)
  );

  c66_rx_descr u_rx (
    .clk(clk), .rst(rst), .bypass(bypass),
    .in_valid(rx_blk_valid), .in_ready(rx_blk_ready), .in_block(rx_block),
    .out_valid(rx_valid), .out_ready(rx_ready),
    .out_payload(rx_payload), .out_ctrl(rx_ctrl), .out_err(rx_hdr_err)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !tx_blk_valid && !rx_valid); // R9
endmodule

// File: tb/sim_sync66_coder.sv
module sim_sync66_coder;
  logic clk = 0;
  logic rst = 1;
  logic bypass = 0;
  logic tx_valid = 0, tx_ctrl = 0;
  logic [63:0] tx_payload = '0;
  logic tx_ready, tx_blk_valid;
  logic tx_blk_ready = 1;
  logic [65:0] tx_block;
  logic rx_blk_valid = 0;
  logic [65:0] rx_block = '0;
  logic rx_blk_ready, rx_valid;
  logic rx_ready = 1;
  logic [63:0] rx_payload;
  logic rx_ctrl, rx_hdr_err;

  int checks = 0, fails = 0, cyc = 0;
  bit stall_en = 0;
  logic [57:0] txm_st = '0, rxm_st = '0, gen_st = '0;
  logic [65:0] tq[$]; string ttag[$];
  logic [65:0] rq[$]; string rtag[$];

  always #10 clk = ~clk; // 50 MHz

  sync66_coder u0 (.*);

  // Scrambler/descrambler recursion from R2/R3: returns {state, bits}.
  function automatic logic [121:0] ref_code(input logic [57:0] st, input logic [63:0] d, input bit rxm);
    logic [57:0] h = st;
    logic [63:0] o;
    for (int i = 0; i < 64; i++) begin
      o[i] = d[i] ^ h[38] ^ h[57];
      h = {h[56:0], rxm ? d[i] : o[i]};
    end
    return {h, o};
  endfunction

  task automatic check(bit ok, string tag, logic [65:0] act, logic [65:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    tx_blk_ready = stall_en ? 1'($urandom % 2) : 1'b1;
    rx_ready     = stall_en ? 1'($urandom % 2) : 1'b1;
  end

  // Transmit monitor
  logic t_pend = 0; logic [65:0] t_hold;
  always @(negedge clk) if (!rst) begin
    if (t_pend) check(tx_blk_valid && tx_block == t_hold, "R8 tx hold", tx_block, t_hold);
    t_pend = tx_blk_valid && !tx_blk_ready;
    t_hold = tx_block;
    if (tx_blk_valid && tx_blk_ready) begin
      if (tq.size() == 0) check(0, "R8 tx unexpected block", tx_block, '0);
      else begin
        logic [65:0] e; string g;
        e = tq.pop_front(); g = ttag.pop_front();
        check(tx_block == e, g, tx_block, e);
      end
    end
  end

  // Receive monitor
  logic r_pend = 0; logic [65:0] r_hold;
  always @(negedge clk) if (!rst) begin
    if (r_pend) check(rx_valid && {rx_hdr_err, rx_ctrl, rx_payload} == r_hold, "R8 rx hold",
                      {rx_hdr_err, rx_ctrl, rx_payload}, r_hold);
    r_pend = rx_valid && !rx_ready;
    r_hold = {rx_hdr_err, rx_ctrl, rx_payload};
    if (rx_valid && rx_ready) begin
      if (rq.size() == 0) check(0, "R8 rx unexpected block", {rx_hdr_err, rx_ctrl, rx_payload}, '0);
      else begin
        logic [65:0] e; string g;
        e = rq.pop_front(); g = rtag.pop_front();
        check({rx_hdr_err, rx_ctrl, rx_payload} == e, g, {rx_hdr_err, rx_ctrl, rx_payload}, e);
      end
    end
  end

  task automatic tx_send(bit ctrl, logic [63:0] pld, bit byp, string tag);
    logic [121:0] r;
    logic [1:0] h;
    h = ctrl ? 2'b10 : 2'b01;
    if (byp) tq.push_back({pld, h});
    else begin
      r = ref_code(txm_st, pld, 0);
      txm_st = r[121:64];
      tq.push_back({r[63:0], h});
    end
    ttag.push_back(tag);
    @(negedge clk);
    tx_valid = 1; tx_ctrl = ctrl; tx_payload = pld; bypass = byp;
    while (!tx_ready) @(negedge clk);
    @(posedge clk); #2;
    tx_valid = 0; bypass = 0;
  endtask

  task automatic rx_send(logic [1:0] h, logic [63:0] w, bit byp, logic [65:0] exp, string tag);
    rq.push_back(exp); rtag.push_back(tag);
    @(negedge clk);
    rx_blk_valid = 1; rx_block = {w, h}; bypass = byp;
    while (!rx_blk_ready) @(negedge clk);
    @(posedge clk); #2;
    rx_blk_valid = 0; bypass = 0;
  endtask

  // Far-end scrambles pld; rx model tracks the design's receive state.
  task automatic rx_stream(logic [1:0] h, logic [63:0] pld, bit use_model, string tag);
    logic [121:0] g, m;
    logic [63:0] e;
    g = ref_code(gen_st, pld, 0); gen_st = g[121:64];
    m = ref_code(rxm_st, g[63:0], 1); rxm_st = m[121:64];
    e = use_model ? m[63:0] : pld;
    rx_send(h, g[63:0], 0, {(h == 2'b00 || h == 2'b11), (h == 2'b10), e}, tag);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cyc);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    check(!tx_blk_valid && !rx_valid, "R9 outputs idle", {tx_blk_valid, rx_valid}, 0);
    check(tx_ready && rx_blk_ready, "R9 inputs ready", {tx_ready, rx_blk_ready}, 2'b11);

    // Transmit: header and scrambling under several patterns
    tx_send(0, 64'h0, 0, "R2 zero payload");
    tx_send(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R1 ctrl header, ones");
    tx_send(0, 64'hAAAA_5555_AAAA_5555, 0, "R2 alternating");
    for (int i = 0; i < 6; i++) tx_send(i % 2, 64'h0123_4567_89AB_CDEF + i, 0, "R1 R2 counting");
    tx_send(0, 64'hDEAD_BEEF_0000_1111, 1, "R7 tx bypass raw");
    tx_send(1, 64'h1357_9BDF_2468_ACE0, 0, "R7 tx state frozen");
    stall_en = 1;
    for (int i = 0; i < 12; i++) tx_send(i[0], {2{i[31:0] * 32'h9E37_79B9}}, 0, "R8 tx under stall");
    stall_en = 0;

    // Receive: in-sync stream returns original payloads
    for (int i = 0; i < 4; i++) rx_stream(2'b01, {i[31:0], ~i[31:0]}, 0, "R3 descramble data");
    rx_stream(2'b10, 64'hCAFE_F00D_1234_5678, 0, "R5 ctrl header");
    rx_stream(2'b00, 64'h1111_2222_3333_4444, 0, "R5 header 00 error");
    rx_stream(2'b11, 64'h5555_6666_7777_8888, 0, "R5 header 11 error");
    rx_stream(2'b01, 64'h9999_AAAA_BBBB_CCCC, 0, "R5 state advanced over error");

    // Single-bit error spread
    begin
      logic [121:0] g, m;
      logic [63:0] p, w, mask;
      p = 64'h0F0F_F0F0_3C3C_C3C3;
      g = ref_code(gen_st, p, 0); gen_st = g[121:64];
      w = g[63:0] ^ (64'd1 << 5);
      m = ref_code(rxm_st, w, 1); rxm_st = m[121:64];
      mask = (64'd1 << 5) | (64'd1 << 44) | (64'd1 << 63);
      rx_send(2'b01, w, 0, {2'b00, p ^ mask}, "R6 three bits corrupted");
      rx_stream(2'b01, 64'h7777_0000_FFFF_1234, 0, "R6 no spread into next block");
    end

    // Self-synchronization from an unrelated far-end state
    gen_st = 58'h2A5_F00D_C0DE_1234;
    rx_stream(2'b01, 64'h8421_8421_8421_8421, 1, "R4 first block after jump");
    rx_stream(2'b01, 64'hFEDC_BA98_7654_3210, 0, "R4 recovered second block");
    rx_stream(2'b10, 64'h0000_0000_0000_0001, 0, "R4 recovered third block");

    // Receive bypass keeps the state
    rx_send(2'b01, 64'h0BAD_CAFE_0BAD_CAFE, 1, {2'b00, 64'h0BAD_CAFE_0BAD_CAFE}, "R7 rx bypass raw");
    rx_stream(2'b01, 64'h2468_1357_2468_1357, 0, "R7 rx state frozen");

    stall_en = 1;
    for (int i = 0; i < 12; i++) rx_stream(2'b01, {2{i[31:0] ^ 32'hA5A5_0F0F}}, 0, "R8 rx under stall");
    stall_en = 0;

    for (int i = 0; i < 2000 && (tq.size() != 0 || rq.size() != 0); i++) @(posedge clk);
    check(tq.size() == 0, "R8 tx queue drained", tq.size(), 0);
    check(rq.size() == 0, "R8 rx queue drained", rq.size(), 0);
    summary();
  end
endmodule